// File: doc/BRIEF.md
# Loss-of-Clock Supervisor

This block is the control state machine that decides how a PLL-based clock system reacts when its reference clock, its feedback clock or its lock indication goes away. It watches presence flags for the reference, the feedback clock and a backup self-clock oscillator, and it watches the PLL lock flag. Each flag first passes through a synchronizer. From these flags and the configuration inputs the block reports one of four operating modes, keeps two sticky status flags and can raise a reset request when lock is lost.

Two regimes are handled. In normal running, a clock loss moves the block to self-clocked operation, which then holds until reset, or to a static stuck state. A lock loss raises a flag and can request a reset. In stop mode the clocks may disappear. When stop ends, the block either waits for full recovery with its flags left untouched, or, with fast wakeup set, runs self-clocked while the reference is missing. In the fast-wakeup case it returns to unlocked normal operation as soon as both clocks are back, and it posts each flag only when the matching signal has returned.

Top module: `losssup_top`

## Requirements
- R1: After reset `opMode` reads 3 (stuck/held), both flags and `rstReq` are 0. The block leaves this hold only once reference, feedback and lock are all present, and then reports 0 (external) when `pllModeSel` is 0 or 1 (normal) when it is 1.
- R2: Presence and lock inputs pass through a two-stage synchronizer. A lock drop therefore shows on the outputs at the third rising edge after it, and not at the second.
- R3: In external mode the block ignores loss of any clock, loss of lock and stop requests. `opMode` stays 0 and both flags stay 0.
- R4: In normal running, loss of the reference or feedback clock sets `clockLost`. The mode becomes 2 (self-clocked) if `clkLossEn` and `scmAlive` are both 1, otherwise 3 (stuck). Either mode then holds until reset, even if the clocks return.
- R5: When the reference and lock are lost in the same cycle during normal running, the event is handled as a reference loss only. `clockLost` sets, `lockLost` stays 0 and no reset request is raised.
- R6: Loss of lock during normal running with both clocks present sets `lockLost` and keeps mode 1. With `lockRstEn` at 1 it raises `rstReq` for exactly one cycle. With `lockRstEn` at 0 no pulse appears.
- R7: With `fastWake` at 0, after stop ends the block returns to mode 1 once reference, feedback and lock are all back, and leaves both flags unchanged. If they are not all back within `WAKE_LIMIT` cycles, it goes to mode 3.
- R8: With `fastWake` at 1, while the reference is missing after stop the mode is 2, whatever `clkLossEn` holds. If `scmAlive` is absent at that point, the mode is 3.
- R9: With `fastWake` at 1, when the reference and feedback return the mode becomes 1 even without lock. `clockLost` sets at that point and not earlier. `lockLost` sets only when lock returns.
- R10: With `fastWake` at 1, if the reference is present but the feedback clock does not return within `WAKE_LIMIT` cycles after stop, the mode becomes 3.
- R11: Both flags are sticky. `flagClr[1]` clears `clockLost` and `flagClr[0]` clears `lockLost` on the next edge. When a set and a clear meet in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refPresent | input | 1 | Reference clock present (asynchronous) |
| fbPresent | input | 1 | PLL feedback clock present (asynchronous) |
| lockIn | input | 1 | PLL lock indication (asynchronous) |
| scmAlive | input | 1 | Self-clock oscillator running (asynchronous) |
| pllModeSel | input | 1 | 0 external clock, 1 normal PLL |
| clkLossEn | input | 1 | Allow self-clocked fallback on clock loss |
| lockRstEn | input | 1 | Request reset on loss of lock |
| fastWake | input | 1 | Fast-wakeup recovery after stop |
| stopReq | input | 1 | Stop mode request, level |
| flagClr | input | 2 | Write-one-to-clear strobes: [1] clock flag, [0] lock flag |
| opMode | output | 2 | 0 external, 1 normal, 2 self-clocked, 3 stuck |
| clockLost | output | 1 | Sticky loss-of-clock flag |
| lockLost | output | 1 | Sticky loss-of-lock flag |
| rstReq | output | 1 | Single-cycle reset request |

## Verification
Two functions can act on the same cycle. A loss-of-lock event can set `lockLost` in the very cycle that software strobes `flagClr[0]`. Separately, a reference loss and a lock loss can arrive on the same edge. The bench provokes the first case by counting the synchronizer latency and placing the clear strobe on exactly the edge where the flag sets, then checks that the flag survives. It provokes the second case by dropping reference and lock together, and judges the result by a set `clockLost`, a clear `lockLost` and an absent reset pulse. Randomized rounds mix clear strobes with lock drops and compare against a flag model in the bench.

// File: rtl/losssup_pkg.sv
package losssup_pkg;

  typedef enum logic [1:0] {
    MODE_EXT   = 2'd0,
    MODE_NRM   = 2'd1,
    MODE_SCM   = 2'd2,
    MODE_STUCK = 2'd3
  } opMode_e;

  typedef enum logic [3:0] {
    ST_HOLD  = 4'd0,
    ST_EXT   = 4'd1,
    ST_RUN   = 4'd2,
    ST_STOP  = 4'd3,
    ST_WAKE  = 4'd4,
    ST_SCMW  = 4'd5,
    ST_FWAKE = 4'd6,
    ST_SCML  = 4'd7,
    ST_STUCK = 4'd8
  } supState_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic setClkFlag;
    logic setLockFlag;
    logic setClkPend;
    logic setLockPend;
    logic clrClkPend;
    logic clrLockPend;
    logic cntClr;
    logic cntRun;
    logic rstPulse;
  } ctrlStrobe_t;

  // Conditions reported by the datapath to the control FSM
  typedef struct packed {
    logic refOk;
    logic fbOk;
    logic lockOk;
    logic scmOk;
    logic lockFall;
    logic clkPend;
    logic lockPend;
    logic timeout;
  } dpStatus_t;

endpackage

// File: rtl/losssup_sync.sv
module losssup_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : gStage
    if (i == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe[i] <= '0;
        else       pipe[i] <= din;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe[i] <= '0;
        else       pipe[i] <= pipe[i-1];
      end
    end
  end

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/losssup_datapath.sv
module losssup_datapath
  import losssup_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WAKE_LIMIT  = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        refPresent,
  input  logic        fbPresent,
  input  logic        lockIn,
  input  logic        scmAlive,
  input  logic [1:0]  flagClr,
  input  ctrlStrobe_t ctrl,
  output dpStatus_t   status,
  output logic        clockLost,
  output logic        lockLost,
  output logic        rstReq
);

  localparam int SENSE_W = 4;
  localparam int CNT_W   = $clog2(WAKE_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAKE_LIMIT - 1);

  logic [SENSE_W-1:0] rawSense;
  logic [SENSE_W-1:0] syncSense;
  logic               lockPrev;
  logic               clkPend;
  logic               lockPend;
  logic [CNT_W-1:0]   waitCnt;
  logic               timeout;

  assign rawSense = {scmAlive, lockIn, fbPresent, refPresent};

  losssup_sync #(
    .WIDTH (SENSE_W),
    .STAGES(SYNC_STAGES)
  ) uSync (
    .clk (clk),
    .rstN(rstN),
    .din (rawSense),
    .dout(syncSense)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lockPrev <= 1'b0;
    else       lockPrev <= syncSense[2];
  end

  // Pending loss records for stop-mode recovery
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPend  <= 1'b0;
      lockPend <= 1'b0;
    end else begin
      if (ctrl.clrClkPend)      clkPend <= 1'b0;
      else if (ctrl.setClkPend) clkPend <= 1'b1;
      if (ctrl.clrLockPend)      lockPend <= 1'b0;
      else if (ctrl.setLockPend) lockPend <= 1'b1;
    end
  end

  // Recovery window counter
  assign timeout = ctrl.cntRun && (waitCnt == CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       waitCnt <= '0;
    else if (ctrl.cntClr)            waitCnt <= '0;
    else if (ctrl.cntRun && !timeout) waitCnt <= waitCnt + 1'b1;
  end

  // Sticky flags: a set in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clockLost <= 1'b0;
      lockLost  <= 1'b0;
      rstReq    <= 1'b0;
    end else begin
      clockLost <= ctrl.setClkFlag  | (clockLost & ~flagClr[1]);
      lockLost  <= ctrl.setLockFlag | (lockLost  & ~flagClr[0]);
      rstReq    <= ctrl.rstPulse;
    end
  end

  always_comb begin
    status.refOk    = syncSense[0];
    status.fbOk     = syncSense[1];
    status.lockOk   = syncSense[2];
    status.scmOk    = syncSense[3];
    status.lockFall = lockPrev & ~syncSense[2];
    status.clkPend  = clkPend;
    status.lockPend = lockPend;
    status.timeout  = timeout;
  end

endmodule

// File: rtl/losssup_control.sv
module losssup_control
  import losssup_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pllModeSel,
  input  logic        clkLossEn,
  input  logic        lockRstEn,
  input  logic        fastWake,
  input  logic        stopReq,
  input  dpStatus_t   status,
  output ctrlStrobe_t ctrl,
  output supState_e   state,
  output opMode_e     opMode
);

  supState_e nextState;
  logic      clocksOk;

  assign clocksOk = status.refOk & status.fbOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_HOLD;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctrl      = '0;
    ctrl.cntClr = 1'b1;
    unique case (state)
      ST_HOLD: begin
        if (clocksOk && status.lockOk)
          nextState = pllModeSel ? ST_RUN : ST_EXT;
      end
      ST_EXT: ;
      ST_RUN: begin
        if (!clocksOk) begin
          // Reference loss dominates any concurrent lock loss
          ctrl.setClkFlag = 1'b1;
          nextState = (clkLossEn && status.scmOk) ? ST_SCML : ST_STUCK;
        end else if (stopReq) begin
          nextState = ST_STOP;
        end else if (status.lockPend) begin
          if (status.lockOk) begin
            ctrl.setLockFlag = 1'b1;
            ctrl.clrLockPend = 1'b1;
          end
        end else if (status.lockFall) begin
          ctrl.setLockFlag = 1'b1;
          ctrl.rstPulse    = lockRstEn;
        end
      end
      ST_STOP: begin
        ctrl.setClkPend  = !clocksOk;
        ctrl.setLockPend = !status.lockOk;
        if (!stopReq) begin
          if (!fastWake)          nextState = ST_WAKE;
          else if (status.refOk)  nextState = ST_FWAKE;
          else                    nextState = status.scmOk ? ST_SCMW : ST_STUCK;
        end
      end
      ST_WAKE: begin
        if (clocksOk && status.lockOk) begin
          ctrl.clrClkPend  = 1'b1;
          ctrl.clrLockPend = 1'b1;
          nextState = ST_RUN;
        end else begin
          ctrl.cntClr = 1'b0;
          ctrl.cntRun = 1'b1;
          if (status.timeout) nextState = ST_STUCK;
        end
      end
      ST_SCMW: begin
        if (!status.scmOk)     nextState = ST_STUCK;
        else if (status.refOk) nextState = ST_FWAKE;
      end
      ST_FWAKE: begin
        if (!status.refOk) begin
          nextState = status.scmOk ? ST_SCMW : ST_STUCK;
        end else if (status.fbOk) begin
          ctrl.setClkFlag = status.clkPend;
          ctrl.clrClkPend = 1'b1;
          nextState = ST_RUN;
        end else begin
          ctrl.cntClr = 1'b0;
          ctrl.cntRun = 1'b1;
          if (status.timeout) nextState = ST_STUCK;
        end
      end
      ST_SCML:  ;
      ST_STUCK: ;
      default:  nextState = ST_HOLD;
    endcase
  end

  always_comb begin
    unique case (state)
      ST_EXT:                    opMode = MODE_EXT;
      ST_RUN, ST_STOP, ST_WAKE,
      ST_FWAKE:                  opMode = MODE_NRM;
      ST_SCMW, ST_SCML:          opMode = MODE_SCM;
      default:                   opMode = MODE_STUCK;
    endcase
  end

endmodule

// File: rtl/losssup_top.sv
module losssup_top
  import losssup_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WAKE_LIMIT  = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refPresent,
  input  logic       fbPresent,
  input  logic       lockIn,
  input  logic       scmAlive,
  input  logic       pllModeSel,
  input  logic       clkLossEn,
  input  logic       lockRstEn,
  input  logic       fastWake,
  input  logic       stopReq,
  input  logic [1:0] flagClr,
  output logic [1:0] opMode,
  output logic       clockLost,
  output logic       lockLost,
  output logic       rstReq
);

  ctrlStrobe_t ctrlBus;
  dpStatus_t   dpStatus;
  supState_e   ctrlState;
  opMode_e     modeEnum;

  losssup_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .WAKE_LIMIT (WAKE_LIMIT)
  ) uDatapath (
    .clk       (clk),
    .rstN      (rstN),
    .refPresent(refPresent),
    .fbPresent (fbPresent),
    .lockIn    (lockIn),
    .scmAlive  (scmAlive),
    .flagClr   (flagClr),
    .ctrl      (ctrlBus),
    .status    (dpStatus),
    .clockLost (clockLost),
    .lockLost  (lockLost),
    .rstReq    (rstReq)
  );

  losssup_control uControl (
    .clk       (clk),
    .rstN      (rstN),
    .pllModeSel(pllModeSel),
    .clkLossEn (clkLossEn),
    .lockRstEn (lockRstEn),
    .fastWake  (fastWake),
    .stopReq   (stopReq),
    .status    (dpStatus),
    .ctrl      (ctrlBus),
    .state     (ctrlState),
    .opMode    (modeEnum)
  );

  assign opMode = modeEnum;

endmodule

// File: rtl/losssup_checker.sv
module losssup_checker
  import losssup_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic [3:0] stateVal,
  input logic       refOk,
  input logic       fbOk,
  input logic       lockOk,
  input logic [1:0] opMode,
  input logic [1:0] flagClr,
  input logic       clockLost,
  input logic       lockLost,
  input logic       rstReq
);

  AST_HOLD_UNTIL_CLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (stateVal == ST_HOLD && !(refOk && fbOk && lockOk)) |=> (stateVal == ST_HOLD)); // R1

  AST_EXT_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (opMode == MODE_EXT) |=> (opMode == MODE_EXT)); // R3

  AST_SCM_LATCHED: assert property (@(posedge clk) disable iff (!rstN)
    (stateVal == ST_SCML) |=> (stateVal == ST_SCML)); // R4

  AST_STUCK_FINAL: assert property (@(posedge clk) disable iff (!rstN)
    (stateVal == ST_STUCK) |=> (stateVal == ST_STUCK)); // R4

  AST_RSTREQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq); // R6

  AST_RSTREQ_FROM_RUN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstReq) |-> ($past(stateVal) == ST_RUN)); // R6

  AST_CLKFLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clockLost) |-> $past(flagClr[1])); // R11

  AST_LOCKFLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockLost) |-> $past(flagClr[0])); // R11

endmodule

bind losssup_top losssup_checker uChecker (
  .clk      (clk),
  .rstN     (rstN),
  .stateVal (ctrlState),
  .refOk    (dpStatus.refOk),
  .fbOk     (dpStatus.fbOk),
  .lockOk   (dpStatus.lockOk),
  .opMode   (opMode),
  .flagClr  (flagClr),
  .clockLost(clockLost),
  .lockLost (lockLost),
  .rstReq   (rstReq)
);

// File: tb/tb_losssup_top.sv
module tb_losssup_top;

  localparam int CLK_PERIOD = 10;
  localparam int WAKE_LIM   = 32;

  logic       clk = 1'b0;
  logic       rstN;
  logic       refPresent, fbPresent, lockIn, scmAlive;
  logic       pllModeSel, clkLossEn, lockRstEn, fastWake, stopReq;
  logic [1:0] flagClr;
  logic [1:0] opMode;
  logic       clockLost, lockLost, rstReq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  losssup_top #(.SYNC_STAGES(2), .WAKE_LIMIT(WAKE_LIM)) dut (
    .clk(clk), .rstN(rstN), .refPresent(refPresent), .fbPresent(fbPresent),
    .lockIn(lockIn), .scmAlive(scmAlive), .pllModeSel(pllModeSel),
    .clkLossEn(clkLossEn), .lockRstEn(lockRstEn), .fastWake(fastWake),
    .stopReq(stopReq), .flagClr(flagClr), .opMode(opMode),
    .clockLost(clockLost), .lockLost(lockLost), .rstReq(rstReq)
  );

  function automatic logic expFlag(logic prev, logic clr, logic setEv);
    return setEv | (prev & ~clr);
  endfunction

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doReset(logic pllSel);
    rstN = 1'b0;
    refPresent = 0; fbPresent = 0; lockIn = 0; scmAlive = 0;
    pllModeSel = pllSel; clkLossEn = 0; lockRstEn = 0; fastWake = 0;
    stopReq = 0; flagClr = 2'b00;
    cyc(3);
    rstN = 1'b1;
    cyc(1);
  endtask

  task automatic bringUp();
    refPresent = 1; fbPresent = 1; lockIn = 1; scmAlive = 1;
    cyc(5);
  endtask

  task automatic countPulses(int n, output int pulses);
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rstReq) pulses++;
    end
  endtask

  task automatic enterStopDropAll(logic keepRef);
    stopReq = 1; cyc(3);
    refPresent = keepRef; fbPresent = 0; lockIn = 0;
    cyc(5);
  endtask

  initial begin
    int pulses;
    logic exClk, exLock;
    void'($urandom(32'd4242));

    // Reset state and release gating
    doReset(1'b1);
    check("R1 reset mode", opMode, 3);
    check("R1 reset clockLost", clockLost, 0);
    check("R1 reset lockLost", lockLost, 0);
    check("R1 reset rstReq", rstReq, 0);
    refPresent = 1; fbPresent = 1; cyc(6);
    check("R1 held without lock", opMode, 3);
    lockIn = 1; cyc(4);
    check("R1 release to normal", opMode, 1);

    // External mode ignores everything
    doReset(1'b0);
    bringUp();
    check("R1 release to external", opMode, 0);
    stopReq = 1; refPresent = 0; fbPresent = 0; lockIn = 0; cyc(6);
    stopReq = 0; cyc(6);
    check("R3 ext mode kept", opMode, 0);
    check("R3 ext clockLost", clockLost, 0);
    check("R3 ext lockLost", lockLost, 0);

    // Lock loss timing and reset request pulse
    doReset(1'b1);
    bringUp();
    lockRstEn = 1;
    lockIn = 0;
    cyc(2);
    check("R2 no pulse at second edge", rstReq, 0);
    check("R2 no flag at second edge", lockLost, 0);
    cyc(1);
    check("R6 pulse at third edge", rstReq, 1);
    check("R6 lockLost set", lockLost, 1);
    cyc(1);
    check("R6 pulse single cycle", rstReq, 0);
    check("R6 mode stays normal", opMode, 1);
    flagClr = 2'b01; cyc(1); flagClr = 2'b00; cyc(1);
    check("R11 W1C lock flag", lockLost, 0);

    // Set and clear in the same cycle; no pulse with enable clear
    lockIn = 1; cyc(5);
    lockRstEn = 0;
    lockIn = 0;
    cyc(2);
    flagClr = 2'b01;
    @(negedge clk);
    if (rstReq) pulses = 1; else pulses = 0;
    flagClr = 2'b00;
    check("R11 set beats clear", lockLost, 1);
    check("R6 no pulse when disabled", pulses, 0);

    // Double failure: reference and lock together
    doReset(1'b1);
    bringUp();
    clkLossEn = 1; lockRstEn = 1;
    refPresent = 0; lockIn = 0;
    countPulses(6, pulses);
    check("R5 self-clocked mode", opMode, 2);
    check("R5 clockLost set", clockLost, 1);
    check("R5 lockLost clear", lockLost, 0);
    check("R5 no reset pulse", pulses, 0);
    refPresent = 1; lockIn = 1; cyc(8);
    check("R4 self-clocked holds", opMode, 2);

    // Feedback loss without fallback enable
    doReset(1'b1);
    bringUp();
    fbPresent = 0; cyc(5);
    check("R4 stuck without enable", opMode, 3);
    check("R4 clockLost set", clockLost, 1);
    fbPresent = 1; cyc(6);
    check("R4 stuck holds", opMode, 3);

    // Slow wakeup: recovery and timeout
    doReset(1'b1);
    bringUp();
    enterStopDropAll(1'b0);
    check("R7 mode in stop", opMode, 1);
    stopReq = 0; cyc(5);
    refPresent = 1; fbPresent = 1; lockIn = 1; cyc(6);
    check("R7 slow recovery mode", opMode, 1);
    check("R7 slow clockLost", clockLost, 0);
    check("R7 slow lockLost", lockLost, 0);
    enterStopDropAll(1'b0);
    stopReq = 0; cyc(WAKE_LIM + 10);
    check("R7 slow timeout stuck", opMode, 3);

    // Fast wakeup: self-clocked while reference missing, then unlocked normal
    doReset(1'b1);
    bringUp();
    fastWake = 1; clkLossEn = 0;
    enterStopDropAll(1'b0);
    stopReq = 0; cyc(6);
    check("R8 self-clocked regardless of enable", opMode, 2);
    check("R9 clock flag deferred", clockLost, 0);
    refPresent = 1; fbPresent = 1; cyc(6);
    check("R9 unlocked normal", opMode, 1);
    check("R9 clockLost at clock return", clockLost, 1);
    check("R9 lock flag deferred", lockLost, 0);
    lockIn = 1; cyc(5);
    check("R9 lockLost at lock return", lockLost, 1);

    // Fast wakeup without self-clock oscillator
    doReset(1'b1);
    bringUp();
    fastWake = 1;
    enterStopDropAll(1'b0);
    scmAlive = 0; cyc(4);
    stopReq = 0; cyc(6);
    check("R8 stuck without self-clock", opMode, 3);

    // Fast wakeup, reference kept, feedback never returns
    doReset(1'b1);
    bringUp();
    fastWake = 1;
    enterStopDropAll(1'b1);
    stopReq = 0; cyc(6);
    check("R10 waiting in normal", opMode, 1);
    cyc(WAKE_LIM + 6);
    check("R10 feedback timeout stuck", opMode, 3);

    // Random rounds: clear strobes mixed with lock drops
    doReset(1'b1);
    bringUp();
    exClk = 0; exLock = 0;
    for (int it = 0; it < 24; it++) begin
      logic drop, rEn;
      logic [1:0] clr;
      drop = 1'($urandom % 2);
      rEn  = 1'($urandom % 2);
      clr  = 2'($urandom % 4);
      lockRstEn = rEn;
      flagClr = clr; cyc(1); flagClr = 2'b00; cyc(1);
      exClk  = expFlag(exClk, clr[1], 1'b0);
      exLock = expFlag(exLock, clr[0], 1'b0);
      check("R11 random clear lock", lockLost, exLock);
      check("R11 random clear clock", clockLost, exClk);
      if (drop) lockIn = 0;
      countPulses(6, pulses);
      exLock = expFlag(exLock, 1'b0, drop);
      check("R6 random lockLost", lockLost, exLock);
      check("R6 random pulses", pulses, (drop && rEn) ? 1 : 0);
      check("R6 random mode", opMode, 1);
      lockIn = 1; cyc(5);
    end

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule